// File: doc/BRIEF.md
# Byte-Lane Insert Load Unit

This unit performs a partial-register load. It takes a base address, a raw displacement field, a lane select, an access size and the present contents of a 32-bit destination register. It issues one memory read for a byte or a halfword and waits for the data. It then writes the loaded value into the chosen lane of the destination value. Every other lane keeps its old contents. The merged word comes back with a one-cycle write-enable pulse, and the register file stores it.

A byte access adds the displacement as an unscaled, zero-extended offset. A halfword access doubles the displacement and treats it as signed. A busy flag covers the whole operation. A start that arrives while the unit is busy is dropped, so the caller must wait for busy to fall before it issues the next operation.

Top module: `lane_insert_load`

## Requirements
- R1: After reset, `busy`, `rdReq` and `wbValid` are low.
- R2: In byte mode (`isHalf`=0) the read address is `baseAddr` plus bits 10:0 of `dispRaw`, zero-extended and unscaled. Bit 11 of `dispRaw` has no effect on the address.
- R3: In halfword mode (`isHalf`=1) the read address is `baseAddr` plus the 12-bit `dispRaw` shifted left by one and sign-extended, which gives an offset from -4096 to +4094.
- R4: In byte mode `rdData[7:0]` is written into the byte chosen by `laneSel`: 0 selects bits 7:0, 1 selects 15:8, 2 selects 23:16 and 3 selects 31:24. `rdData[15:8]` has no effect.
- R5: In halfword mode `rdData[15:0]` is written into bits 15:0 when `laneSel[0]`=0 and into bits 31:16 when `laneSel[0]`=1. `laneSel[1]` has no effect.
- R6: Every bit of `wbData` outside the target lane equals the `destOld` value that was captured with the start command.
- R7: From the cycle after an accepted start, `rdReq` stays high with a constant `rdAddr`, and `rdHalf` equals the size. This lasts up to and including the cycle in which `rdValid` is high.
- R8: `wbValid` is high for exactly one cycle, namely the cycle after `rdValid` was seen with `rdReq` high. The unit is idle in the cycle after that.
- R9: `busy` is high from the cycle after an accepted start through the writeback cycle. A `startValid` that arrives while `busy` is high changes neither the address, nor the result, nor the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start command, accepted only when idle |
| baseAddr | input | 32 | Base register value |
| dispRaw | input | 12 | Raw displacement field |
| laneSel | input | 2 | Target lane (byte) or half select in bit 0 (halfword) |
| isHalf | input | 1 | 1 = halfword access, 0 = byte access |
| destOld | input | 32 | Current destination register value |
| busy | output | 1 | Operation in flight |
| rdReq | output | 1 | Memory read request |
| rdAddr | output | 32 | Read address |
| rdHalf | output | 1 | Read size, 1 = halfword |
| rdValid | input | 1 | Read data valid |
| rdData | input | 16 | Read data, byte in bits 7:0 |
| wbValid | output | 1 | Writeback enable pulse |
| wbData | output | 32 | Merged register value |

## Verification
The bench sweeps every lane in both sizes with several data and destination patterns. A mask shifted by the wrong amount would damage a neighbouring lane or leave stale bits, and the arithmetic check against the untouched lanes exposes either fault.

The displacement corners cover the following faults:
- `dispRaw` = 0x7FF and 0x800 in byte mode: a design that kept bit 11 or scaled the field would put the read off by 2048 bytes or by a factor of two.
- 0x800 and 0xFFF in halfword mode: a missing sign extension would produce a large forward offset instead of -4096 or -2.

Two further cases check the input bits that must be ignored. `laneSel[1]` is set in halfword mode, and a value is placed on `rdData[15:8]` in byte mode. Start commands are also issued while the unit is busy. A design that did not gate them would change the held address or start a second read.

// File: rtl/lane_ins_pkg.sv
package lane_ins_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_WRITE = 2'd2
  } lane_ins_state_e;

  typedef struct packed {
    logic loadOps;
    logic loadResult;
  } lane_ins_strobe_t;
endpackage

// File: rtl/lane_ins_ctrl.sv
module lane_ins_ctrl
  import lane_ins_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             rdValid,
  output lane_ins_strobe_t strobe,
  output logic             busy,
  output logic             rdReq,
  output logic             wbValid
);
  lane_ins_state_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: if (startValid) begin
        strobe.loadOps = 1'b1;
        stateD = ST_WAIT;
      end
      ST_WAIT: if (rdValid) begin
        strobe.loadResult = 1'b1;
        stateD = ST_WRITE;
      end
      ST_WRITE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy    = (stateQ != ST_IDLE);
  assign rdReq   = (stateQ == ST_WAIT);
  assign wbValid = (stateQ == ST_WRITE);

  // R8: writeback is a single-cycle pulse
  a_r8_wb_single: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid);
  // R9: an accepted start raises busy and the request next cycle
  a_r9_busy_on_start: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busy) |=> (busy && rdReq));
  // R7: request and writeback never overlap
  a_r7_req_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && wbValid));
endmodule

// File: rtl/lane_ins_dpath.sv
module lane_ins_dpath
  import lane_ins_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 32,
  parameter int DISP_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  lane_ins_strobe_t strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DISP_W-1:0] dispRaw,
  input  logic [1:0]        laneSel,
  input  logic              isHalf,
  input  logic [REG_W-1:0]  destOld,
  input  logic [15:0]       rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdHalf,
  output logic [REG_W-1:0]  wbData
);
  localparam int BYTE_W   = 8;
  localparam int HALF_W   = 16;
  localparam int BYTE_OFF = DISP_W - 1;
  localparam int HEXT_W   = ADDR_W - DISP_W - 1;

  logic [1:0]        laneQ;
  logic [REG_W-1:0]  oldQ;
  logic [ADDR_W-1:0] addrNext;
  logic [REG_W-1:0]  laneMask, laneData, merged;
  logic [4:0]        shiftAmt;

  // Address: unscaled zero-extended for bytes, doubled signed for halves
  always_comb begin
    if (isHalf)
      addrNext = baseAddr + {{HEXT_W{dispRaw[DISP_W-1]}}, dispRaw, 1'b0};
    else
      addrNext = baseAddr + ADDR_W'(dispRaw[BYTE_OFF-1:0]);
  end

  // Lane merge: clear target lane, OR in shifted load data
  always_comb begin
    if (rdHalf) begin
      shiftAmt = {laneQ[0], 4'b0000};
      laneMask = REG_W'({HALF_W{1'b1}}) << shiftAmt;
      laneData = REG_W'(rdData[HALF_W-1:0]) << shiftAmt;
    end else begin
      shiftAmt = {laneQ, 3'b000};
      laneMask = REG_W'({BYTE_W{1'b1}}) << shiftAmt;
      laneData = REG_W'(rdData[BYTE_W-1:0]) << shiftAmt;
    end
    merged = (oldQ & ~laneMask) | laneData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr <= '0;
      rdHalf <= 1'b0;
      laneQ  <= '0;
      oldQ   <= '0;
      wbData <= '0;
    end else begin
      if (strobe.loadOps) begin
        rdAddr <= addrNext;
        rdHalf <= isHalf;
        laneQ  <= laneSel;
        oldQ   <= destOld;
      end
      if (strobe.loadResult) wbData <= merged;
    end
  end

  // R7: operands cannot be loaded in the same cycle as the result
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadOps && strobe.loadResult));
endmodule

// File: rtl/lane_insert_load.sv
module lane_insert_load
  import lane_ins_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 32,
  parameter int DISP_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DISP_W-1:0] dispRaw,
  input  logic [1:0]        laneSel,
  input  logic              isHalf,
  input  logic [REG_W-1:0]  destOld,
  output logic              busy,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdHalf,
  input  logic              rdValid,
  input  logic [15:0]       rdData,
  output logic              wbValid,
  output logic [REG_W-1:0]  wbData
);
  lane_ins_strobe_t strobe;

  lane_ins_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .rdValid(rdValid),
    .strobe(strobe), .busy(busy), .rdReq(rdReq), .wbValid(wbValid)
  );

  lane_ins_dpath #(.ADDR_W(ADDR_W), .REG_W(REG_W), .DISP_W(DISP_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseAddr(baseAddr),
    .dispRaw(dispRaw), .laneSel(laneSel), .isHalf(isHalf), .destOld(destOld),
    .rdData(rdData), .rdAddr(rdAddr), .rdHalf(rdHalf), .wbData(wbData)
  );

  // R7: address and size held while waiting for data
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> (rdReq && $stable(rdAddr) && $stable(rdHalf)));
  // R8: data acceptance is followed by writeback
  a_r8_wb_after_data: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdValid) |=> (wbValid && !rdReq));
  // R9: writeback returns to idle
  a_r9_idle_after_wb: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !busy);
endmodule

// File: tb/lane_insert_load_bench.sv
module lane_insert_load_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [11:0] dispRaw = '0;
  logic [1:0]  laneSel = '0;
  logic        isHalf = 1'b0;
  logic [31:0] destOld = '0;
  logic        busy, rdReq, rdHalf, wbValid;
  logic [31:0] rdAddr, wbData;
  logic        rdValid = 1'b0;
  logic [15:0] rdData = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lane_insert_load u_lane_insert_load (
    .clk(clk), .rstN(rstN), .startValid(startValid), .baseAddr(baseAddr),
    .dispRaw(dispRaw), .laneSel(laneSel), .isHalf(isHalf), .destOld(destOld),
    .busy(busy), .rdReq(rdReq), .rdAddr(rdAddr), .rdHalf(rdHalf),
    .rdValid(rdValid), .rdData(rdData), .wbValid(wbValid), .wbData(wbData)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  function automatic logic [31:0] expAddr(bit h, logic [31:0] b, logic [11:0] d);
    if (h) return b + {{19{d[11]}}, d, 1'b0};
    return b + {21'd0, d[10:0]};
  endfunction

  function automatic logic [31:0] expMerge(bit h, logic [1:0] l,
                                           logic [31:0] o, logic [15:0] dat);
    int sh;
    logic [31:0] m, v;
    if (h) begin
      sh = l[0] ? 16 : 0;
      m = 32'h0000_FFFF << sh;
      v = {16'd0, dat} << sh;
    end else begin
      sh = 8 * int'(l);
      m = 32'h0000_00FF << sh;
      v = {24'd0, dat[7:0]} << sh;
    end
    return (o & ~m) | v;
  endfunction

  // One full operation; drives inputs on negedges, samples on negedges
  task automatic runOp(bit h, logic [1:0] l, logic [31:0] b, logic [11:0] d,
                       logic [31:0] o, logic [15:0] dat, int lat);
    logic [31:0] ea, em;
    ea = expAddr(h, b, d);
    em = expMerge(h, l, o, dat);
    startValid = 1'b1; isHalf = h; laneSel = l; baseAddr = b;
    dispRaw = d; destOld = o;
    @(negedge clk);
    startValid = 1'b0;
    chk("R9 busy after start", {31'd0, busy}, 32'd1);
    chk("R7 rdReq raised", {31'd0, rdReq}, 32'd1);
    chk(h ? "R3 half address" : "R2 byte address", rdAddr, ea);
    chk("R7 rdHalf size", {31'd0, rdHalf}, {31'd0, h});
    for (int w = 0; w < lat; w++) begin
      // ignored start while busy (R9)
      startValid = 1'b1; baseAddr = ~b; dispRaw = ~d; destOld = ~o;
      isHalf = ~h; laneSel = ~l;
      @(negedge clk);
      startValid = 1'b0;
      chk("R7 request held", {31'd0, rdReq}, 32'd1);
      chk("R9 address unchanged by busy start", rdAddr, ea);
      chk("R8 no early writeback", {31'd0, wbValid}, 32'd0);
    end
    rdValid = 1'b1; rdData = dat;
    @(negedge clk);
    rdValid = 1'b0; rdData = 16'hDEAD;
    chk("R8 writeback pulse", {31'd0, wbValid}, 32'd1);
    chk("R8 request dropped", {31'd0, rdReq}, 32'd0);
    chk("R9 busy in writeback", {31'd0, busy}, 32'd1);
    chk(h ? "R5 R6 half merge" : "R4 R6 byte merge", wbData, em);
    startValid = 1'b1; baseAddr = 32'hFFFF_0000;
    @(negedge clk);
    startValid = 1'b0;
    chk("R8 writeback single cycle", {31'd0, wbValid}, 32'd0);
    chk("R9 idle after writeback, late start ignored", {30'd0, busy, rdReq}, 32'd0);
    chk("R9 result unchanged", wbData, em);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset rdReq", {31'd0, rdReq}, 32'd0);
    chk("R1 reset wbValid", {31'd0, wbValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 R6: every byte lane with several patterns; upper data byte set (R4 ignore)
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 6; p++) begin
        logic [15:0] dat;
        logic [31:0] o;
        dat = 16'((p * 16'h3B29) ^ 16'hC300);
        o = 32'hA5C3_9E17 ^ (32'h1111_1111 * p);
        runOp(1'b0, 2'(l), 32'h2000_0000 + 32'(p * 64), 12'(p * 9), o, dat, p % 3);
      end
    end
    // R5 R6: halfword, all laneSel values (bit 1 must not matter)
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 5; p++) begin
        logic [15:0] dat;
        logic [31:0] o;
        dat = 16'((p * 16'h51F7) + 16'h0101);
        o = 32'h0F1E_2D3C ^ (32'h2468_ACE0 * p);
        runOp(1'b1, 2'(l), 32'h4000_1000, 12'(p * 13), o, dat, (p + l) % 2);
      end
    end
    // R2 displacement corners in byte mode
    runOp(1'b0, 2'd0, 32'h0000_1000, 12'h7FF, 32'hFFFF_FFFF, 16'h0000, 0);
    runOp(1'b0, 2'd3, 32'h0000_1000, 12'h800, 32'h0000_0000, 16'hFFFF, 1);
    runOp(1'b0, 2'd2, 32'hFFFF_FFF0, 12'hFFF, 32'h1234_5678, 16'h00AB, 0);
    // R3 displacement corners in halfword mode
    runOp(1'b1, 2'd0, 32'h0001_0000, 12'h800, 32'hCAFE_BABE, 16'h8001, 0);
    runOp(1'b1, 2'd1, 32'h0001_0000, 12'hFFF, 32'hCAFE_BABE, 16'h7FFE, 2);
    runOp(1'b1, 2'd1, 32'h0001_0000, 12'h7FF, 32'h0000_0000, 16'hFFFF, 0);
    runOp(1'b1, 2'd0, 32'h0000_0002, 12'hFFF, 32'hFFFF_FFFF, 16'h0000, 1);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule